// File: doc/BRIEF.md
# Adaptive Redundancy Mode Controller

This controller decides how many of three reconfigurable slots run a lockstep processor. With zero processors every slot holds an accelerator, which gives the highest performance and is the default. One, two or three processors give simplex, duplex or triplex redundancy. Slot `k` holds a processor exactly when `k` is below the mode value. The controller counts upset events reported by a configuration scrubber over a programmable window. When the count rises above a programmable limit, it steps redundancy up by one level.

A ground command can override the adaptive choice. The command names a mode and a hold time, and the controller keeps that mode until the hold time runs out. After that, adaptive selection takes over again and starts from whatever count the current window holds.

Each mode change is carried out as a series of reconfiguration requests over a request/done handshake. A request is issued only for a slot whose role actually changes. When the processor count goes up, the controller pulses a reset to the redundant subsystem so that the processors realign for lockstep. When the count goes down, no reset is issued.

Top module: `redundancy_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is 0 (accelerator-only), and `pr_req_o`, `sub_rst_o` and `forced_o` are all low.
- R2: While no forced mode is active, a window fault count strictly greater than `fault_limit_i` starts a switch to `mode_o`+1 and clears the count. In mode 3, upsets start no switch.
- R3: A completed switch that raises the processor count gives a one-cycle `sub_rst_o` pulse, in the first cycle in which `mode_o` shows the new value.
- R4: A switch that lowers the processor count never asserts `sub_rst_o`.
- R5: The controller issues requests one at a time, in ascending slot order. Each request stays high with a stable slot and role until `pr_done_i` is sampled high. `mode_o` changes only on the edge that takes the last done.
- R6: The controller requests only slots whose role differs between the old mode and the new mode. `pr_role_o` is 1 to load a processor and 0 to load an accelerator.
- R7: A command (`cmd_valid_i`, with `cmd_mode_i` clamped to 3 and hold time `cmd_hold_i`=H) is taken when the controller is idle. It switches to the named mode and holds `forced_o` high for H+1 cycles. During that time, upsets start no switch.
- R8: When `forced_o` falls, adaptive selection resumes using the fault count the window has gathered, including upsets that arrived while the mode was forced.
- R9: When `window_len_i`=W is nonzero, the fault count restarts every W cycles. On the boundary cycle the count becomes 1 if an upset arrives then, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upset_i | input | 1 | One upset event per cycle high |
| fault_limit_i | input | CNT_W | Count that must be exceeded to escalate |
| window_len_i | input | WIN_W | Window length in cycles, 0 disables clearing |
| cmd_valid_i | input | 1 | Ground command strobe |
| cmd_mode_i | input | MODE_W | Commanded processor count |
| cmd_hold_i | input | HOLD_W | Forced-hold duration |
| pr_done_i | input | 1 | Reconfiguration of the requested slot finished |
| mode_o | output | MODE_W | Current processor count |
| forced_o | output | 1 | Ground-forced mode active |
| pr_req_o | output | 1 | Reconfiguration request |
| pr_slot_o | output | SLOT_W | Slot being reconfigured |
| pr_role_o | output | 1 | 1 processor, 0 accelerator |
| sub_rst_o | output | 1 | Resynchronisation reset for the redundant subsystem |

## Verification
Assertions check on every cycle the rules that can be seen locally. A pending request must stay stable and the mode must not move while a request waits for its done. The reset pulse must occur exactly when the mode value rises. Every requested slot must really change role. The forced hold must last while its timer is nonzero and end when it reaches zero, and the window count must restart at each boundary. Only the bench scenarios can show the behaviours that span a whole sequence. These are escalation at the strict threshold, saturation at triplex, suppression of escalation while forced, re-escalation from upsets gathered during a forced period, the order in which requests arrive, and the clearing of a count that would otherwise have crossed the limit.

// File: rtl/rmc_pkg.sv
package rmc_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } rmc_state_e;
endpackage

// File: rtl/rmc_fault_window.sv
module rmc_fault_window #(
    parameter int CNT_W = 8,
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upset_i,
    input  logic [WIN_W-1:0] window_len_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [CNT_W-1:0] cnt;
    } fw_t;

    fw_t q, d;
    logic edge_hit;

    always_comb begin
        d = q;
        edge_hit = (window_len_i != '0) && (q.win >= window_len_i - WIN_W'(1));
        d.win = edge_hit ? '0 : q.win + WIN_W'(1);
        if (clr_i) begin
            d.cnt = upset_i ? CNT_W'(1) : '0;
        end else if (edge_hit) begin
            d.cnt = upset_i ? CNT_W'(1) : '0;
        end else if (upset_i && q.cnt != CNT_MAX) begin
            d.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt_o = q.cnt;

    // R9: a window boundary leaves at most the single upset of that cycle
    a_r9_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> (cnt_o <= CNT_W'(1)));
endmodule

// File: rtl/rmc_force_timer.sv
module rmc_force_timer #(
    parameter int MODE_W    = 2,
    parameter int HOLD_W    = 16,
    parameter int NUM_SLOTS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [MODE_W-1:0] cmd_mode_i,
    input  logic [HOLD_W-1:0] cmd_hold_i,
    input  logic              take_i,
    output logic              pend_o,
    output logic [MODE_W-1:0] pend_mode_o,
    output logic              forced_o
);
    localparam logic [MODE_W-1:0] MODE_MAX = MODE_W'(NUM_SLOTS);

    typedef struct packed {
        logic              forced;
        logic [HOLD_W-1:0] timer;
        logic              pend;
        logic [MODE_W-1:0] pend_mode;
        logic [HOLD_W-1:0] pend_hold;
    } ft_t;

    ft_t q, d;

    always_comb begin
        d = q;
        if (take_i) begin
            d.forced = 1'b1;
            d.timer  = q.pend_hold;
            d.pend   = 1'b0;
        end else if (q.forced) begin
            if (q.timer == '0) d.forced = 1'b0;
            else               d.timer  = q.timer - HOLD_W'(1);
        end
        if (cmd_valid_i) begin
            d.pend      = 1'b1;
            d.pend_mode = (cmd_mode_i > MODE_MAX) ? MODE_MAX : cmd_mode_i;
            d.pend_hold = cmd_hold_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend_o      = q.pend;
    assign pend_mode_o = q.pend_mode;
    assign forced_o    = q.forced;

    // R7: the forced hold survives while time remains
    a_r7_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
        (q.forced && q.timer != '0) |=> forced_o);
    // R8: the forced hold ends when the timer is spent
    a_r8_hold_expires: assert property (@(posedge clk) disable iff (!rst_n)
        (q.forced && q.timer == '0 && !take_i) |=> !forced_o);
endmodule

// File: rtl/redundancy_mode_ctrl.sv
module redundancy_mode_ctrl
    import rmc_pkg::*;
#(
    parameter int NUM_SLOTS = 3,
    parameter int CNT_W     = 8,
    parameter int WIN_W     = 16,
    parameter int HOLD_W    = 16,
    parameter int MODE_W    = $clog2(NUM_SLOTS + 1),
    parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upset_i,
    input  logic [CNT_W-1:0]  fault_limit_i,
    input  logic [WIN_W-1:0]  window_len_i,
    input  logic              cmd_valid_i,
    input  logic [MODE_W-1:0] cmd_mode_i,
    input  logic [HOLD_W-1:0] cmd_hold_i,
    input  logic              pr_done_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              forced_o,
    output logic              pr_req_o,
    output logic [SLOT_W-1:0] pr_slot_o,
    output logic              pr_role_o,
    output logic              sub_rst_o
);
    localparam logic [MODE_W-1:0] MODE_MAX = MODE_W'(NUM_SLOTS);

    typedef struct packed {
        rmc_state_e        state;
        logic [MODE_W-1:0] mode;
        logic [MODE_W-1:0] tgt;
        logic [MODE_W-1:0] slot;
        logic              sub_rst;
    } ctl_t;

    ctl_t q, d;
    logic              take;
    logic              clr;
    logic [CNT_W-1:0]  fault_cnt;
    logic              pend;
    logic [MODE_W-1:0] pend_mode;
    logic [MODE_W-1:0] hi_bound;

    rmc_fault_window #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_window (
        .clk          (clk),
        .rst_n        (rst_n),
        .upset_i      (upset_i),
        .window_len_i (window_len_i),
        .clr_i        (clr),
        .cnt_o        (fault_cnt)
    );

    rmc_force_timer #(.MODE_W(MODE_W), .HOLD_W(HOLD_W), .NUM_SLOTS(NUM_SLOTS)) u_force (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid_i),
        .cmd_mode_i  (cmd_mode_i),
        .cmd_hold_i  (cmd_hold_i),
        .take_i      (take),
        .pend_o      (pend),
        .pend_mode_o (pend_mode),
        .forced_o    (forced_o)
    );

    assign hi_bound = (q.tgt > q.mode) ? q.tgt : q.mode;

    always_comb begin
        d         = q;
        d.sub_rst = 1'b0;
        take      = 1'b0;
        clr       = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (pend) begin
                    take = 1'b1;
                    if (pend_mode != q.mode) begin
                        d.state = ST_REQ;
                        d.tgt   = pend_mode;
                        d.slot  = (pend_mode < q.mode) ? pend_mode : q.mode;
                    end
                end else if (!forced_o && fault_cnt > fault_limit_i && q.mode != MODE_MAX) begin
                    clr     = 1'b1;
                    d.state = ST_REQ;
                    d.tgt   = q.mode + MODE_W'(1);
                    d.slot  = q.mode;
                end
            end
            ST_REQ: begin
                if (pr_done_i) begin
                    if (q.slot + MODE_W'(1) == hi_bound) begin
                        d.state   = ST_IDLE;
                        d.mode    = q.tgt;
                        d.sub_rst = (q.tgt > q.mode);
                    end else begin
                        d.slot = q.slot + MODE_W'(1);
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{state: ST_IDLE, mode: '0, tgt: '0, slot: '0, sub_rst: 1'b0};
        else        q <= d;
    end

    assign mode_o    = q.mode;
    assign pr_req_o  = (q.state == ST_REQ);
    assign pr_slot_o = q.slot[SLOT_W-1:0];
    assign pr_role_o = (q.slot < q.tgt);
    assign sub_rst_o = q.sub_rst;

    // R5: an unanswered request holds its slot and role, and the mode waits
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_req_o && !pr_done_i) |=> (pr_req_o && $stable(pr_slot_o) && $stable(pr_role_o) && $stable(mode_o)));
    // R6: every requested slot changes role relative to the current mode
    a_r6_slot_changes: assert property (@(posedge clk) disable iff (!rst_n)
        pr_req_o |-> (pr_role_o != (q.slot < q.mode)));
    // R3: a rise in processor count comes with the resync pulse
    a_r3_rst_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o > $past(mode_o)) |-> sub_rst_o);
    // R4: the resync pulse appears only on a rise
    a_r4_rst_only_rise: assert property (@(posedge clk) disable iff (!rst_n)
        sub_rst_o |-> (mode_o > $past(mode_o)));
endmodule

// File: tb/tb_redundancy_mode_ctrl.sv
module tb_redundancy_mode_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upset_i = 1'b0;
    logic [7:0]  fault_limit_i = 8'd2;
    logic [15:0] window_len_i = 16'd4000;
    logic        cmd_valid_i = 1'b0;
    logic [1:0]  cmd_mode_i = '0;
    logic [15:0] cmd_hold_i = '0;
    logic        pr_done_i = 1'b0;
    logic [1:0]  mode_o;
    logic        forced_o;
    logic        pr_req_o;
    logic [1:0]  pr_slot_o;
    logic        pr_role_o;
    logic        sub_rst_o;

    int tests = 0;
    int fails = 0;
    int rst_seen = 0;
    int exp_q[$];
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    redundancy_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .upset_i(upset_i), .fault_limit_i(fault_limit_i),
        .window_len_i(window_len_i), .cmd_valid_i(cmd_valid_i), .cmd_mode_i(cmd_mode_i),
        .cmd_hold_i(cmd_hold_i), .pr_done_i(pr_done_i), .mode_o(mode_o), .forced_o(forced_o),
        .pr_req_o(pr_req_o), .pr_slot_o(pr_slot_o), .pr_role_o(pr_role_o), .sub_rst_o(sub_rst_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: answers requests, compares each against the scoreboard queue
    initial begin
        bit gap;
        gap = 0;
        forever begin
            @(negedge clk);
            if (rst_n && sub_rst_o) rst_seen++;
            if (gap) begin
                pr_done_i = 1'b0;
                gap = 0;
            end else if (rst_n && pr_req_o) begin
                int act;
                act = int'(pr_slot_o) * 2 + int'(pr_role_o);
                if (exp_q.size() == 0) begin
                    chk(0, "R6 unexpected request", act, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(act == e, "R5/R6 request slot*2+role", act, e);
                end
                pr_done_i = 1'b1;
                gap = 1;
            end
        end
    end

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic upset(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) upset_i = 1'b1;
            @(negedge clk) upset_i = 1'b0;
        end
    endtask

    task automatic command(input int m, input int hold);
        @(negedge clk);
        cmd_valid_i = 1'b1;
        cmd_mode_i  = 2'(m);
        cmd_hold_i  = 16'(hold);
        @(negedge clk);
        cmd_valid_i = 1'b0;
    endtask

    task automatic wait_unforced;
        while (forced_o) @(negedge clk);
    endtask

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mode_o == 0, "R1 mode", mode_o, 0);
        chk(!pr_req_o, "R1 req", pr_req_o, 0);
        chk(!sub_rst_o, "R1 sub_rst", sub_rst_o, 0);
        chk(!forced_o, "R1 forced", forced_o, 0);
        rst_n = 1'b1;
        settle(2);

        // R2: count equal to limit does not escalate
        r0 = rst_seen;
        upset(2);
        settle(10);
        chk(mode_o == 0, "R2 at limit no switch", mode_o, 0);
        // R2/R3: exceeding limit -> simplex, slot0 becomes processor
        exp_q.push_back(1);
        upset(1);
        settle(15);
        chk(mode_o == 1, "R2 escalate to 1", mode_o, 1);
        chk(rst_seen - r0 == 1, "R3 reset on rise", rst_seen - r0, 1);

        // R2/R6: to duplex, only slot1 changes
        r0 = rst_seen;
        exp_q.push_back(3);
        upset(3);
        settle(15);
        chk(mode_o == 2, "R2 escalate to 2", mode_o, 2);
        chk(rst_seen - r0 == 1, "R3 reset on rise", rst_seen - r0, 1);

        // to triplex
        r0 = rst_seen;
        exp_q.push_back(5);
        upset(3);
        settle(15);
        chk(mode_o == 3, "R2 escalate to 3", mode_o, 3);
        chk(rst_seen - r0 == 1, "R3 reset on rise", rst_seen - r0, 1);

        // R2: saturation at triplex
        upset(3);
        settle(15);
        chk(mode_o == 3, "R2 saturate", mode_o, 3);

        // R7/R4/R5: forced drop to simplex, slots 1 then 2 become accelerators
        r0 = rst_seen;
        exp_q.push_back(2);
        exp_q.push_back(4);
        command(1, 60);
        settle(12);
        chk(mode_o == 1, "R7 forced mode", mode_o, 1);
        chk(forced_o, "R7 forced flag", forced_o, 1);
        chk(rst_seen - r0 == 0, "R4 no reset on fall", rst_seen - r0, 0);
        chk(exp_q.size() == 0, "R5 both requests done", exp_q.size(), 0);
        // R7: upsets during forced period do not escalate
        upset(3);
        settle(10);
        chk(mode_o == 1, "R7 no adaptive while forced", mode_o, 1);
        // R8: after expiry gathered count escalates
        exp_q.push_back(3);
        wait_unforced();
        settle(12);
        chk(mode_o == 2, "R8 resume adaptive", mode_o, 2);
        chk(rst_seen - r0 == 1, "R8 reset on re-escalation", rst_seen - r0, 1);
        chk(!forced_o, "R8 forced cleared", forced_o, 0);

        // R4/R6: forced drop to accelerator-only, slots 0 then 1
        r0 = rst_seen;
        exp_q.push_back(0);
        exp_q.push_back(2);
        command(0, 5);
        settle(3);
        wait_unforced();
        settle(12);
        chk(mode_o == 0, "R7 forced to 0", mode_o, 0);
        chk(rst_seen - r0 == 0, "R4 no reset on fall", rst_seen - r0, 0);
        chk(exp_q.size() == 0, "R6 requests done", exp_q.size(), 0);

        // R9: window restart keeps split upsets below limit
        window_len_i = 16'd20;
        settle(2);
        upset(2);
        settle(45);
        upset(2);
        settle(15);
        chk(mode_o == 0, "R9 window clears count", mode_o, 0);
        chk(exp_q.size() == 0, "R9 no requests", exp_q.size(), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(negedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule